// File: doc/BRIEF.md
# Latched Event Interrupt Controller

This block collects seven single-cycle event strobes from a timing unit (four capture events, a counter wrap, a period match and a compare match) into sticky flag bits. Each source has its own enable bit. A global status bit makes sure that only one interrupt pulse leaves the block until software acknowledges it. Software services the flags through a write-one-to-clear port. It can also raise any flag through a write-one-to-force port, which is useful for testing.

A mode input says whether the unit runs as a capture timer or as a PWM generator. In capture mode only the four capture sources, plus the wrap, may set their flags. In PWM mode only the period and compare sources, plus the wrap, may set theirs. The flag word and the enable word are brought out as 16-bit read values. The interrupt output is a one-clock pulse for a downstream interrupt controller.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flag word, the enable word and the interrupt output are all 0.
- R2: Flag word layout: bit 0 is the global status bit, bits 1..4 are capture events 1..4, bit 5 is the wrap, bit 6 is the period match and bit 7 is the compare match. Bits 15..8 read 0. The enable word uses the same positions for the seven sources; its bit 0 and bits 15..8 always read 0.
- R3: With the mode input at 0 (capture), a capture strobe sets its flag on the next clock edge, and the flag stays set until it is cleared. With the mode input at 1 (PWM), capture strobes set nothing.
- R4: Period and compare strobes set bits 6 and 7 only when the mode input is 1. The wrap strobe sets bit 5 in either mode.
- R5: When an enabled event flag is set and the global bit is 0, the interrupt output goes high one clock later. In the same cycle the global bit reads 1.
- R6: The interrupt output is high for exactly one clock. No further pulse is issued while the global bit stays 1, even when more enabled flags become set.
- R7: A clear write with a 1 in bit n (n = 1..7) clears that flag. A clear write with 0 bits changes nothing.
- R8: A clear write with bit 0 set clears the global bit. If enabled event flags are still set, a new pulse follows one clock later.
- R9: A force write with a 1 in bit n (n = 1..7) sets that flag in either mode.
- R10: When a set (from a strobe or a force) and a clear hit the same flag in one cycle, the flag ends up set.
- R11: Flags whose enable bit is 0 never cause an interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_mode_i | input | 1 | 0 = capture mode, 1 = PWM mode |
| cap_evt_i | input | 4 | Capture event strobes 1..4 (bit 0 = event 1) |
| wrap_evt_i | input | 1 | Counter wrap strobe |
| prd_evt_i | input | 1 | Period match strobe |
| cmp_evt_i | input | 1 | Compare match strobe |
| en_wr_i | input | 1 | Write strobe for the enable word |
| en_wdata_i | input | 16 | Enable word write data |
| clr_wr_i | input | 1 | Write strobe for the clear port |
| clr_wdata_i | input | 16 | Clear bits (write one to clear) |
| frc_wr_i | input | 1 | Write strobe for the force port |
| frc_wdata_i | input | 16 | Force bits (write one to set) |
| flags_o | output | 16 | Flag word |
| enable_o | output | 16 | Enable word read value |
| irq_o | output | 1 | Single-clock interrupt pulse |

## Verification
Two situations are hard to reach from the ports.

The first is a hardware strobe, or a force, landing in the very cycle that a clear names the same flag. The bench drives the strobe and the clear write together on one falling edge, so both are sampled at the same rising edge. It then reads the flag word on the next falling edge.

The second is a re-issued pulse. To get it, the bench leaves an enabled flag set, clears only the global bit, and looks for a fresh pulse exactly one cycle after that clear. Before doing so, it confirms that further enabled events arriving while the global bit is set produce no pulse.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned CAP_N   = 4;
  localparam int unsigned EVT_N   = CAP_N + 3;
  // bit positions in flag/enable word (bit 0 = global status)
  localparam int unsigned GINT_B  = 0;
  localparam int unsigned CAP_LO  = 1;
  localparam int unsigned WRAP_B  = CAP_LO + CAP_N;
  localparam int unsigned PRD_B   = WRAP_B + 1;
  localparam int unsigned CMP_B   = PRD_B + 1;
  localparam int unsigned TOP_B   = CMP_B;
endpackage

// File: rtl/evt_src_gate.sv
module evt_src_gate
  import evt_irq_pkg::*;
(
  input  logic             pwm_mode_i,
  input  logic [CAP_N-1:0] cap_evt_i,
  input  logic             wrap_evt_i,
  input  logic             prd_evt_i,
  input  logic             cmp_evt_i,
  input  logic             frc_wr_i,
  input  logic [EVT_N-1:0] frc_vec_i,
  output logic [EVT_N-1:0] set_o
);
  logic [EVT_N-1:0] hw_set;
  logic [EVT_N-1:0] frc_set;

  always_comb begin
    hw_set = '0;
    hw_set[CAP_N-1:0] = cap_evt_i & {CAP_N{~pwm_mode_i}};
    hw_set[CAP_N]     = wrap_evt_i;
    hw_set[CAP_N+1]   = prd_evt_i & pwm_mode_i;
    hw_set[CAP_N+2]   = cmp_evt_i & pwm_mode_i;
  end

  assign frc_set = frc_vec_i & {EVT_N{frc_wr_i}};
  assign set_o   = hw_set | frc_set;
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] set_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] flag_o
);
  for (genvar g = 0; g < EVT_N; g++) begin : g_flag
    logic flag_q;
    // set has priority so a coincident event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import evt_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] flag_i,
  input  logic [EVT_N-1:0] en_i,
  input  logic             gint_clr_i,
  output logic             gint_o,
  output logic             irq_o
);
  logic gint_q, irq_q, fire;

  assign fire = (|(flag_i & en_i)) & ~gint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gint_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)            gint_q <= 1'b1;
      else if (gint_clr_i) gint_q <= 1'b0;
    end
  end

  assign gint_o = gint_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_mode_i,
  input  logic [CAP_N-1:0] cap_evt_i,
  input  logic             wrap_evt_i,
  input  logic             prd_evt_i,
  input  logic             cmp_evt_i,
  input  logic             en_wr_i,
  input  logic [REG_W-1:0] en_wdata_i,
  input  logic             clr_wr_i,
  input  logic [REG_W-1:0] clr_wdata_i,
  input  logic             frc_wr_i,
  input  logic [REG_W-1:0] frc_wdata_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] enable_o,
  output logic             irq_o
);
  logic [EVT_N-1:0] en_q;
  logic [EVT_N-1:0] set_vec, clr_vec, flag_vec;
  logic             gint;
  logic             unused_bits;

  assign unused_bits = ^{en_wdata_i[REG_W-1:TOP_B+1], en_wdata_i[GINT_B],
                         clr_wdata_i[REG_W-1:TOP_B+1],
                         frc_wdata_i[REG_W-1:TOP_B+1], frc_wdata_i[GINT_B]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i[TOP_B:CAP_LO];
  end

  assign clr_vec = clr_wdata_i[TOP_B:CAP_LO] & {EVT_N{clr_wr_i}};

  evt_src_gate i_gate (
    .pwm_mode_i (pwm_mode_i),
    .cap_evt_i  (cap_evt_i),
    .wrap_evt_i (wrap_evt_i),
    .prd_evt_i  (prd_evt_i),
    .cmp_evt_i  (cmp_evt_i),
    .frc_wr_i   (frc_wr_i),
    .frc_vec_i  (frc_wdata_i[TOP_B:CAP_LO]),
    .set_o      (set_vec)
  );

  evt_flag_bank i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flag_vec)
  );

  irq_pulse_gen i_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_i     (flag_vec),
    .en_i       (en_q),
    .gint_clr_i (clr_wr_i & clr_wdata_i[GINT_B]),
    .gint_o     (gint),
    .irq_o      (irq_o)
  );

  always_comb begin
    flags_o = '0;
    flags_o[GINT_B] = gint;
    flags_o[TOP_B:CAP_LO] = flag_vec;
    enable_o = '0;
    enable_o[TOP_B:CAP_LO] = en_q;
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_mode_i,
  input logic [CAP_N-1:0] cap_evt_i,
  input logic             wrap_evt_i,
  input logic             prd_evt_i,
  input logic             clr_wr_i,
  input logic [REG_W-1:0] clr_wdata_i,
  input logic             frc_wr_i,
  input logic [REG_W-1:0] frc_wdata_i,
  input logic [REG_W-1:0] flags_o,
  input logic [REG_W-1:0] enable_o,
  input logic             irq_o
);
  p_pulse_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_pulse_sets_gint_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_o[GINT_B]);

  p_no_pulse_while_gint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(flags_o[GINT_B]));

  p_pulse_needs_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |($past(flags_o[TOP_B:CAP_LO] & enable_o[TOP_B:CAP_LO])));

  p_cap_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_mode_i && cap_evt_i[0]) |=> flags_o[CAP_LO]);

  p_wrap_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt_i |=> flags_o[WRAP_B]);

  p_prd_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[PRD_B]) |->
      $past((pwm_mode_i && prd_evt_i) || (frc_wr_i && frc_wdata_i[PRD_B])));

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_wr_i && frc_wdata_i[WRAP_B] && clr_wr_i && clr_wdata_i[WRAP_B])
      |=> flags_o[WRAP_B]);
endmodule

bind evt_irq_ctrl evt_irq_chk i_evt_irq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_mode_i  (pwm_mode_i),
  .cap_evt_i   (cap_evt_i),
  .wrap_evt_i  (wrap_evt_i),
  .prd_evt_i   (prd_evt_i),
  .clr_wr_i    (clr_wr_i),
  .clr_wdata_i (clr_wdata_i),
  .frc_wr_i    (frc_wr_i),
  .frc_wdata_i (frc_wdata_i),
  .flags_o     (flags_o),
  .enable_o    (enable_o),
  .irq_o       (irq_o)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwm_mode_i = 1'b0;
  logic [3:0]  cap_evt_i = '0;
  logic        wrap_evt_i = 1'b0, prd_evt_i = 1'b0, cmp_evt_i = 1'b0;
  logic        en_wr_i = 1'b0, clr_wr_i = 1'b0, frc_wr_i = 1'b0;
  logic [15:0] en_wdata_i = '0, clr_wdata_i = '0, frc_wdata_i = '0;
  logic [15:0] flags_o, enable_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_mode_i(pwm_mode_i),
    .cap_evt_i(cap_evt_i), .wrap_evt_i(wrap_evt_i), .prd_evt_i(prd_evt_i),
    .cmp_evt_i(cmp_evt_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i), .frc_wr_i(frc_wr_i),
    .frc_wdata_i(frc_wdata_i), .flags_o(flags_o), .enable_o(enable_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every stimulus is applied for one clock, then removed; results read at negedge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic step();
    @(negedge clk_i);
    cap_evt_i = '0; wrap_evt_i = 0; prd_evt_i = 0; cmp_evt_i = 0;
    en_wr_i = 0; clr_wr_i = 0; frc_wr_i = 0;
  endtask

  task automatic wr_en(input logic [15:0] d);
    en_wr_i = 1; en_wdata_i = d; step();
  endtask
  task automatic wr_clr(input logic [15:0] d);
    clr_wr_i = 1; clr_wdata_i = d; step();
  endtask
  task automatic wr_frc(input logic [15:0] d);
    frc_wr_i = 1; frc_wdata_i = d; step();
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_o, 16'h0000);
    chk("R1 enable", enable_o, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_enable_layout();
    wr_en(16'hFFFF);
    chk("R2 enable readback", enable_o, 16'h00FE);
    wr_en(16'h0000);
    chk("R2 enable cleared", enable_o, 16'h0000);
  endtask

  task automatic t_capture_mode();
    pwm_mode_i = 0;
    cap_evt_i = 4'b0101; step();
    chk("R3 capture flags 1,3", flags_o, 16'h000A);
    prd_evt_i = 1; cmp_evt_i = 1; wrap_evt_i = 1; step();
    chk("R4 cap mode gates prd/cmp, wrap sets", flags_o, 16'h002A);
    idle(2);
    chk("R3 sticky", flags_o, 16'h002A);
    chk("R11 no pulse when disabled", {15'd0, irq_o}, 16'h0000);
    wr_clr(16'h00FF);
    chk("R7 clear all", flags_o, 16'h0000);
  endtask

  task automatic t_pwm_mode();
    pwm_mode_i = 1;
    cap_evt_i = 4'b1111; step();
    chk("R3 pwm mode blocks capture", flags_o, 16'h0000);
    prd_evt_i = 1; step();
    chk("R4 prd in pwm", flags_o, 16'h0040);
    cmp_evt_i = 1; wrap_evt_i = 1; step();
    chk("R4 cmp and wrap in pwm", flags_o, 16'h00E0);
    wr_clr(16'h00E0);
    chk("R7 clear pwm flags", flags_o, 16'h0000);
    pwm_mode_i = 0;
  endtask

  task automatic t_pulse();
    wr_en(16'h0022);  // wrap + capture 1
    wrap_evt_i = 1; step();
    chk("R5 flag visible, no pulse yet", {flags_o[15:1], irq_o}, 16'h0020);
    idle(1);
    chk("R5 pulse", {15'd0, irq_o}, 16'h0001);
    chk("R5 global bit", flags_o, 16'h0021);
    idle(1);
    chk("R6 single clock", {15'd0, irq_o}, 16'h0000);
    cap_evt_i = 4'b0001; step();
    idle(3);
    chk("R6 blocked while global set", {15'd0, irq_o}, 16'h0000);
    chk("R6 flags", flags_o, 16'h0023);
    wr_clr(16'h0023);
    idle(2);
    chk("R7 all cleared, no pulse", {flags_o[15:1], irq_o}, 16'h0000);
  endtask

  task automatic t_reissue();
    wr_frc(16'h0020);
    idle(1);
    chk("R5 pulse from forced flag", {15'd0, irq_o}, 16'h0001);
    wr_clr(16'h0001);
    chk("R8 global cleared, flag kept", {flags_o[15:1], irq_o}, 16'h0020);
    idle(1);
    chk("R8 re-issued pulse", {flags_o[15:1], irq_o}, 16'h0021);
    chk("R8 global set again", flags_o, 16'h0021);
    wr_clr(16'h0021);
    wr_en(16'h0000);
    chk("R8 cleanup", flags_o, 16'h0000);
  endtask

  task automatic t_force();
    pwm_mode_i = 1;
    wr_frc(16'h001E);
    chk("R9 force capture flags in pwm mode", flags_o, 16'h001E);
    pwm_mode_i = 0;
    wr_frc(16'h00C0);
    chk("R9 force prd/cmp in capture mode", flags_o, 16'h00DE);
    wr_clr(16'h0000);
    chk("R7 zero clear no effect", flags_o, 16'h00DE);
    wr_clr(16'h0014);
    chk("R7 partial clear", flags_o, 16'h00CA);
    wr_clr(16'h00FF);
  endtask

  task automatic t_set_wins();
    pwm_mode_i = 0;
    cap_evt_i = 4'b0001; clr_wr_i = 1; clr_wdata_i = 16'h0002; step();
    chk("R10 strobe beats clear", flags_o, 16'h0002);
    frc_wr_i = 1; frc_wdata_i = 16'h0040; clr_wr_i = 1; clr_wdata_i = 16'h0042; step();
    chk("R10 force beats clear", flags_o, 16'h0040);
    wr_clr(16'h00FF);
    chk("R10 cleanup", flags_o, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    rst_ni = 1;
    idle(1);
    t_reset();
    t_enable_layout();
    t_capture_mode();
    t_pwm_mode();
    t_pulse();
    t_reissue();
    t_force();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule